// File: doc/BRIEF.md
# Supervisor Reset Pulse Stretcher

This block produces the system reset of a supply supervisor. It watches two digital conditions: a supply-good flag, which an analog comparator has already produced, and an active-low manual reset request from a push-button or from external logic. While either condition calls for reset, the block holds reset asserted. Once both conditions have cleared, it keeps reset asserted for a fixed number of clock cycles and only then releases it.

Both inputs are asynchronous to the clock, so each passes through a two-flop synchronizer. The hold counter reloads to its full length on every cycle in which a cause is still present. A button that bounces, or a brownout that comes back during a pulse, therefore only makes the pulse longer and can never shorten it. A watchdog can reset the system only by being wired, outside the block, to the manual input. The reset output is driven in both polarities, and each polarity has its own register.

Top module: `sup_reset_stretch`

## Requirements
- R1: Let the supply-good input be low at two consecutive rising edges. Then the active-low reset output is low after the second rising edge that follows the first of those edges, and it stays low for as long as the input stays low.
- R2: Let the supply-good input return high and stay high, with the manual input high. Then reset stays asserted through the (HOLD_CYCLES+2)th rising edge after the return and deasserts at the (HOLD_CYCLES+3)th edge. The return is counted from the first edge that samples the input high.
- R3: A low-to-high release of the manual reset input starts the same hold as R2. Reset deasserts at the (HOLD_CYCLES+3)th rising edge after the first edge that samples the input high.
- R4: A new cause that occurs during a running hold restarts the hold at full length, timed from when that cause clears. No reset pulse lasts fewer than HOLD_CYCLES cycles.
- R5: The active-high reset output is at all times the logical inverse of the active-low reset output.
- R6: The manual input has no debounce filter. A burst of bounces yields one reset pulse, which ends HOLD_CYCLES+3 rising edges after the last low-to-high transition.
- R7: While rst_ni is low, reset is asserted. After rst_ni is released with both inputs healthy, reset deasserts at the (HOLD_CYCLES+3)th rising edge.
- R8: When both causes are active, the hold is timed from the cause that clears last.
- R9: While both inputs have been healthy for three edges and reset is deasserted, reset stays deasserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| supply_ok_i | input | 1 | Supply above threshold when high (asynchronous) |
| mr_ni | input | 1 | Manual reset request, active low (asynchronous) |
| rst_no | output | 1 | System reset, active low |
| rst_o | output | 1 | System reset, active high |

## Verification
The bench models the expected reset level cycle by cycle from the history of sampled causes. It compares that model with both outputs on every cycle. Directed phases cover the following cases:
- The power-on release. A design that counts from the wrong edge shows up here as a release one cycle early or late.
- A brownout and a manual press. These expose a counter that starts on assertion instead of on release.
- A bounce burst. A design that reacts to each bounce would emit several short pulses here.
- A retrigger in the middle of a pulse. A counter that does not reload would release early.
- Overlapping causes. A design that times the hold from the wrong cause would release while the other cause is still held.

Random dips then mix these patterns at arbitrary spacing.

// File: rtl/sup_rst_pkg.sv
package sup_rst_pkg;

  typedef struct packed {
    logic supply_low;
    logic manual;
  } cause_t;

  localparam int unsigned SYNC_STAGES_DEF = 2;

endpackage

// File: rtl/sup_rst_sync.sv
module sup_rst_sync #(
  parameter int unsigned WIDTH   = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stage_q[s] <= RST_VAL;
      end else if (s == 0) begin
        stage_q[s] <= d_i;
      end else begin
        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/sup_rst_cause.sv
module sup_rst_cause
  import sup_rst_pkg::*;
(
  input  logic   supply_ok_s_i,
  input  logic   mr_n_s_i,
  output cause_t cause_o,
  output logic   any_o
);

  always_comb begin
    cause_o.supply_low = ~supply_ok_s_i;
    cause_o.manual     = ~mr_n_s_i;
    any_o              = |cause_o;
  end

endmodule

// File: rtl/sup_rst_hold.sv
module sup_rst_hold #(
  parameter int unsigned HOLD_CYCLES = 25_000_000,
  localparam int unsigned CNT_W = $clog2(HOLD_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cause_i,
  output logic busy_o
);

  localparam logic [CNT_W-1:0] LOAD = CNT_W'(HOLD_CYCLES);

  logic [CNT_W-1:0] cnt_q;

  // reload on every active cycle so a late cause never shortens the pulse
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= LOAD;
    end else if (cause_i) begin
      cnt_q <= LOAD;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy_o = cause_i | (cnt_q != '0);

endmodule

// File: rtl/sup_rst_out.sv
module sup_rst_out (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic assert_i,
  output logic rst_no,
  output logic rst_o
);

  // separate flops per polarity, asserted from power-on
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_no <= 1'b0;
      rst_o  <= 1'b1;
    end else begin
      rst_no <= ~assert_i;
      rst_o  <= assert_i;
    end
  end

endmodule

// File: rtl/sup_reset_stretch.sv
module sup_reset_stretch
  import sup_rst_pkg::*;
#(
  parameter int unsigned HOLD_CYCLES = 25_000_000,
  parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic supply_ok_i,
  input  logic mr_ni,
  output logic rst_no,
  output logic rst_o
);

  logic [1:0] raw_in, sync_in;
  cause_t     cause;
  logic       cause_any;
  logic       busy;

  assign raw_in = {supply_ok_i, mr_ni};

  // reset value reads as "both causes active"
  sup_rst_sync #(
    .WIDTH   (2),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (2'b00)
  ) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (raw_in),
    .q_o    (sync_in)
  );

  sup_rst_cause i_cause (
    .supply_ok_s_i (sync_in[1]),
    .mr_n_s_i      (sync_in[0]),
    .cause_o       (cause),
    .any_o         (cause_any)
  );

  sup_rst_hold #(
    .HOLD_CYCLES (HOLD_CYCLES)
  ) i_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cause_i (cause_any),
    .busy_o  (busy)
  );

  sup_rst_out i_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .assert_i (busy),
    .rst_no   (rst_no),
    .rst_o    (rst_o)
  );

endmodule

// File: rtl/sup_reset_stretch_chk.sv
module sup_reset_stretch_chk #(
  parameter int unsigned HOLD_CYCLES = 25_000_000
) (
  input logic clk_i,
  input logic rst_ni,
  input logic supply_ok_i,
  input logic mr_ni,
  input logic rst_no,
  input logic rst_o
);

  logic [31:0] low_len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_len_q <= '0;
    end else if (rst_no) begin
      low_len_q <= '0;
    end else if (low_len_q < HOLD_CYCLES) begin
      low_len_q <= low_len_q + 1'b1;
    end
  end

  p_polarity_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_o == ~rst_no);

  p_supply_low_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!supply_ok_i && !$past(supply_ok_i) && !$past(supply_ok_i, 2)) |=> !rst_no);

  p_manual_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mr_ni && !$past(mr_ni) && !$past(mr_ni, 2)) |=> !rst_no);

  p_min_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_no) |-> (low_len_q >= HOLD_CYCLES));

  p_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_no && supply_ok_i && mr_ni && $past(supply_ok_i) && $past(mr_ni)
     && $past(supply_ok_i, 2) && $past(mr_ni, 2)) |=> rst_no);

endmodule

bind sup_reset_stretch sup_reset_stretch_chk #(
  .HOLD_CYCLES (HOLD_CYCLES)
) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .supply_ok_i (supply_ok_i),
  .mr_ni       (mr_ni),
  .rst_no      (rst_no),
  .rst_o       (rst_o)
);

// File: tb/test_sup_reset_stretch.sv
module test_sup_reset_stretch;

  localparam int HOLD = 40;

  logic clk = 1'b0;
  logic rst_ni = 1'b1;
  logic supply_ok = 1'b1;
  logic mr_n = 1'b1;
  logic rst_no, rst_o;

  int n_checks = 0;
  int n_fail = 0;
  bit check_en = 1'b0;
  string tag = "R7";
  logic [63:0] hist = '1;  // hist[k]: cause seen at the edge k edges ago

  always #4 clk = ~clk;

  sup_reset_stretch #(.HOLD_CYCLES(HOLD)) i_sup_reset_stretch (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .supply_ok_i (supply_ok),
    .mr_ni       (mr_n),
    .rst_no      (rst_no),
    .rst_o       (rst_o)
  );

  // asserted iff a cause was seen between 2 and HOLD+2 edges ago (R1, R2, R3, R7)
  function automatic logic exp_asserted(input logic [63:0] h);
    logic r = 1'b0;
    for (int k = 2; k <= HOLD + 2; k++) r |= h[k];
    return r;
  endfunction

  always @(posedge clk) begin
    hist = {hist[62:0], (!rst_ni || !supply_ok || !mr_n)};
  end

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (check_en) begin
      check(tag, rst_no, !exp_asserted(hist));
      check("R5", rst_o, ~rst_no);
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    #1 rst_ni = 1'b0;
    cycles(2);
    check_en = 1'b1;
    tag = "R7";                       // R7: asserted in reset and through POR hold
    cycles(4);
    rst_ni = 1'b1;
    cycles(HOLD + 10);
    tag = "R9";                       // R9: stays quiet
    cycles(20);

    tag = "R1";                       // R1 then R2
    supply_ok = 1'b0; cycles(10);
    tag = "R2";
    supply_ok = 1'b1; cycles(HOLD + 10);

    tag = "R3";                       // R3: single press
    mr_n = 1'b0; cycles(3);
    mr_n = 1'b1; cycles(HOLD + 10);

    tag = "R6";                       // R6: bounce burst
    for (int i = 0; i < 12; i++) begin
      mr_n = ~mr_n;
      cycles(1 + ($urandom % 5));
    end
    mr_n = 1'b1; cycles(HOLD + 10);

    tag = "R4";                       // R4: retrigger mid-hold
    supply_ok = 1'b0; cycles(5);
    supply_ok = 1'b1; cycles(HOLD / 2);
    mr_n = 1'b0; cycles(2);
    mr_n = 1'b1; cycles(HOLD + 10);
    supply_ok = 1'b0; cycles(1);      // one-cycle glitch
    supply_ok = 1'b1; cycles(HOLD + 10);

    tag = "R8";                       // R8: overlapping causes
    supply_ok = 1'b0; cycles(3);
    mr_n = 1'b0; cycles(5);
    supply_ok = 1'b1; cycles(15);
    mr_n = 1'b1; cycles(HOLD + 10);
    mr_n = 1'b0; supply_ok = 1'b0; cycles(4);
    mr_n = 1'b1; cycles(HOLD + 5);
    supply_ok = 1'b1; cycles(HOLD + 10);

    tag = "R4";                       // random dips at arbitrary spacing
    for (int i = 0; i < 3000; i++) begin
      supply_ok = ($urandom % 100) >= 2;
      mr_n      = ($urandom % 100) >= 2;
      cycles(1);
    end
    supply_ok = 1'b1; mr_n = 1'b1;
    cycles(HOLD + 10);

    check_en = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule